// File: doc/BRIEF.md
# Multibit Noise-Shaping Tail Stage for a Cascaded Delta-Sigma Modulator

This block is a later stage of a multistage noise-shaping cascade. It takes the residual word left behind by the stage in front of it and noise-shapes that residual. Each sample produces a short signed quantized code, which recombination logic outside the block uses to cancel the error of the earlier stage. The block also exports its own residual, so several copies can be chained. A cascade with two extra first-order stages, for example, feeds the residual output of one copy into the input of the next copy, and both copies run on the same sample enable.

The parameter `ORDER` selects the loop order. With `ORDER = 1`, the stored quantization error is added to the incoming word. With `ORDER = 2`, the last two stored errors are combined as twice the newer one minus the older one, which gives second-order shaping. In both orders the quantizer saturates at the ends of its code range instead of wrapping. Because of this, a large input limits the amplitude of the code rather than corrupting it.

Top module: `mash_tail_stage`

## Requirements
- R1: While `rst_n` is low, `q_o`, `res_o` and all stored error state are zero. The reset acts asynchronously.
- R2: In a cycle where `en` is low, no output or state changes, whatever value `res_i` has. When `en` returns high, processing continues from the state held before the pause.
- R3: With `ORDER = 1`, the loop sum is `res_i + e1`, where `e1` is the error stored at the previous enabled edge.
- R4: With `ORDER = 2`, the loop sum is `res_i + 2*e1 - e2`. Here `e1` is the error stored at the previous enabled edge and `e2` is the error stored at the edge before that.
- R5: The code is `floor(sum / 2^(IN_W-Q_W))` in two's complement, clamped to the range `-2^(Q_W-1)` to `2^(Q_W-1)-1`. It never wraps.
- R6: The difference `d = sum - code*2^(IN_W-Q_W)` is computed at each enabled edge. `res_o` takes `d` clamped to the signed `IN_W`-bit range, and the stored error takes `d` clamped to the signed `IN_W+1`-bit range. `q_o` and `res_o` are registered and change only at an enabled rising edge.
- R7: Start from reset and apply a constant input `x` that never drives the quantizer into its limits. Over any number N of enabled samples, the sum of `code*2^(IN_W-Q_W)` differs from `N*x` by less than `2^(IN_W-Q_W)`, for either order.
- R8: A second first-order copy fed from the first copy's `res_o`, on the same `en`, produces at each enabled edge the code and residual of R3, R5 and R6 applied to the residual that the first copy held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sample enable shared by every stage of the cascade |
| res_i | input | IN_W | Signed residual from the preceding stage |
| q_o | output | Q_W | Signed quantized code (registered) |
| res_o | output | IN_W | Signed residual for a following stage (registered) |

## Verification
Limiter saturation and residual export can happen on the same edge. When the code clamps, the difference is larger than one quantizer step, so both the residual and the stored error must be clamped. The bench makes this happen by sweeping every input value in a reduced configuration, by holding the input at full scale in both directions, and by letting the stored error run up to its clamp. In each enabled cycle the bench compares code and residual against an arithmetic model that it builds from R3 to R6.

// File: rtl/mash_tail_stage.sv
module mash_tail_stage #(
  parameter int IN_W  = 22,
  parameter int Q_W   = 8,
  parameter int ORDER = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic signed [IN_W-1:0] res_i,
  output logic signed [Q_W-1:0]  q_o,
  output logic signed [IN_W-1:0] res_o
);
  localparam int SH   = IN_W - Q_W;
  localparam int E_W  = IN_W + 1;
  localparam int S_W  = IN_W + 3;
  localparam int QHI  = 2**(Q_W-1) - 1;
  localparam int QLO  = -(2**(Q_W-1));
  localparam int EHI  = 2**(E_W-1) - 1;
  localparam int ELO  = -(2**(E_W-1));
  localparam int RHI  = 2**(IN_W-1) - 1;
  localparam int RLO  = -(2**(IN_W-1));
  localparam int OVER = (QHI + 1) * (2**SH);
  localparam int UNDR = QLO * (2**SH);

  logic signed [E_W-1:0] e1, e_nx;
  logic signed [S_W-1:0] sum, sum_sh, qv, diff;
  logic signed [Q_W-1:0] qsel;
  logic signed [IN_W-1:0] r_nx;

  generate
    if (ORDER == 2) begin : g_ord2
      logic signed [E_W-1:0] e2;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) e2 <= '0;
        else if (en) e2 <= e1;
      assign sum = S_W'(res_i) + (S_W'(e1) <<< 1) - S_W'(e2);
    end else begin : g_ord1
      assign sum = S_W'(res_i) + S_W'(e1);
    end
  endgenerate

  assign sum_sh = sum >>> SH;

  always_comb begin
    if (sum_sh > S_W'(QHI))      qsel = Q_W'(QHI);
    else if (sum_sh < S_W'(QLO)) qsel = Q_W'(QLO);
    else                         qsel = sum_sh[Q_W-1:0];
  end

  assign qv   = S_W'(qsel) <<< SH;
  assign diff = sum - qv;

  always_comb begin
    if (diff > S_W'(EHI))      e_nx = E_W'(EHI);
    else if (diff < S_W'(ELO)) e_nx = E_W'(ELO);
    else                       e_nx = diff[E_W-1:0];
    if (diff > S_W'(RHI))      r_nx = IN_W'(RHI);
    else if (diff < S_W'(RLO)) r_nx = IN_W'(RLO);
    else                       r_nx = diff[IN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      e1    <= '0;
      q_o   <= '0;
      res_o <= '0;
    end else if (en) begin
      e1    <= e_nx;
      q_o   <= qsel;
      res_o <= r_nx;
    end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_o) && $stable(res_o) && $stable(e1)); // R2

  AST_LIMIT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    en && (sum >= OVER) |=> q_o == Q_W'(QHI)); // R5

  AST_LIMIT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    en && (sum < UNDR) |=> q_o == Q_W'(QLO)); // R5

  AST_RECON: assert property (@(posedge clk) disable iff (!rst_n)
    en && (diff >= RLO) && (diff <= RHI)
    |=> ((S_W'(q_o) <<< SH) + S_W'(res_o)) == $past(sum)); // R6
endmodule

// File: tb/test_mash_tail_stage.sv
module test_mash_tail_stage;
  localparam int IN_W = 10;
  localparam int Q_W  = 4;
  localparam int SH   = IN_W - Q_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en;
  logic signed [IN_W-1:0] x;
  logic signed [Q_W-1:0]  q1, q2, q3;
  logic signed [IN_W-1:0] r1, r2, r3;

  mash_tail_stage #(.IN_W(IN_W), .Q_W(Q_W), .ORDER(1)) i_mash_tail_stage (
    .clk(clk), .rst_n(rst_n), .en(en), .res_i(x), .q_o(q1), .res_o(r1));
  mash_tail_stage #(.IN_W(IN_W), .Q_W(Q_W), .ORDER(2)) i_mash_tail_stage_o2 (
    .clk(clk), .rst_n(rst_n), .en(en), .res_i(x), .q_o(q2), .res_o(r2));
  mash_tail_stage #(.IN_W(IN_W), .Q_W(Q_W), .ORDER(1)) i_mash_tail_stage_chain (
    .clk(clk), .rst_n(rst_n), .en(en), .res_i(r1), .q_o(q3), .res_o(r3));

  int checks = 0, fails = 0;
  int me1[3], me2[3], mq[3], mr[3];

  function automatic int clampi(int v, int lo, int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic void mstep(int k, int ord, int xin);
    int s, q, d;
    s = (ord == 2) ? xin + 2*me1[k] - me2[k] : xin + me1[k];
    q = clampi(s >>> SH, -(2**(Q_W-1)), 2**(Q_W-1)-1);
    d = s - q * (2**SH);
    me2[k] = me1[k];
    me1[k] = clampi(d, -(2**IN_W), 2**IN_W - 1);
    mq[k]  = q;
    mr[k]  = clampi(d, -(2**(IN_W-1)), 2**(IN_W-1)-1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string t1, string t2, string t3);
    chk(t1, int'(q1), mq[0]); chk(t1, int'(r1), mr[0]);
    chk(t2, int'(q2), mq[1]); chk(t2, int'(r2), mr[1]);
    chk(t3, int'(q3), mq[2]); chk(t3, int'(r3), mr[2]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; x = '0;
    for (int k = 0; k < 3; k++) begin me1[k] = 0; me2[k] = 0; mq[k] = 0; mr[k] = 0; end
    #1;
    check_all("R1 reset ord1", "R1 reset ord2", "R1 reset chain");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(int xv, bit e);
    int in3;
    @(negedge clk);
    x = IN_W'(xv); en = e;
    @(posedge clk);
    if (e) begin
      in3 = mr[0];
      mstep(0, 1, xv);
      mstep(1, 2, xv);
      mstep(2, 1, in3);
    end
    #1;
  endtask

  initial begin
    #(8 * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hq1, hr1, hq2, hr2, acc1, acc2;
    int cx[5];
    rst_n = 1'b0; en = 1'b0; x = '0;
    do_reset();

    // full sweep, ascending then descending: R3 R4 R5 R6 R8
    for (int v = -(2**(IN_W-1)); v < 2**(IN_W-1); v++) begin
      step(v, 1'b1);
      check_all("R3/R5/R6 ord1 sweep", "R4/R5/R6 ord2 sweep", "R8 chain sweep");
    end
    for (int v = 2**(IN_W-1) - 1; v >= -(2**(IN_W-1)); v -= 3) begin
      step(v, 1'b1);
      check_all("R3/R5/R6 ord1 down", "R4/R5/R6 ord2 down", "R8 chain down");
    end

    // full scale: limiter coincides with residual clamp, R5 R6
    do_reset();
    for (int n = 0; n < 40; n++) begin
      step(2**(IN_W-1) - 1, 1'b1);
      check_all("R5/R6 ord1 +fs", "R5/R6 ord2 +fs", "R8 chain +fs");
    end
    chk("R5 ord1 high limit", int'(q1), 2**(Q_W-1) - 1);
    for (int n = 0; n < 40; n++) begin
      step(-(2**(IN_W-1)), 1'b1);
      check_all("R5/R6 ord1 -fs", "R5/R6 ord2 -fs", "R8 chain -fs");
    end
    chk("R5 ord1 low limit", int'(q1), -(2**(Q_W-1)));

    // enable low: inputs ignored, R2
    for (int n = 0; n < 5; n++) begin step(100 + 17*n, 1'b1); end
    hq1 = int'(q1); hr1 = int'(r1); hq2 = int'(q2); hr2 = int'(r2);
    for (int n = 0; n < 8; n++) begin
      step(-300 + 90*n, 1'b0);
      chk("R2 hold q ord1", int'(q1), hq1); chk("R2 hold r ord1", int'(r1), hr1);
      chk("R2 hold q ord2", int'(q2), hq2); chk("R2 hold r ord2", int'(r2), hr2);
    end
    for (int n = 0; n < 6; n++) begin
      step(211 - 50*n, 1'b1);
      check_all("R2 resume ord1", "R2 resume ord2", "R2 resume chain");
    end

    // mean tracking for constant inputs, R7
    cx[0] = -400; cx[1] = -1; cx[2] = 0; cx[3] = 37; cx[4] = 300;
    foreach (cx[i]) begin
      do_reset();
      acc1 = 0; acc2 = 0;
      for (int n = 1; n <= 256; n++) begin
        step(cx[i], 1'b1);
        acc1 += int'(q1) * (2**SH);
        acc2 += int'(q2) * (2**SH);
        if (n % 64 == 0) begin
          chk("R7 ord1 mean", ((acc1 - n*cx[i]) < 2**SH && (n*cx[i] - acc1) < 2**SH) ? 1 : 0, 1);
          chk("R7 ord2 mean", ((acc2 - n*cx[i]) < 2**SH && (n*cx[i] - acc2) < 2**SH) ? 1 : 0, 1);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule